// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Arbiter

This block runs the bus cycle in which a processor core acknowledges a pending interrupt. When the core hands it a nonzero request level, it starts a CPU-space cycle. The function code and the address carry that level, so any interrupt source can see which level is being acknowledged. The same level is written into the core's stored interrupt priority mask.

Up to eight interrupt-source modules answer. Each one reports its request level, a 4-bit arbitration number, an 8-bit vector number, an autovector choice and a ready flag. Only sources at the acknowledged level with a nonzero arbitration number compete. The one with the largest arbitration number wins. The cycle ends in one of three ways:
- with the winner's own vector;
- with an autovector formed from the level;
- with the spurious vector, after a bus monitor times out and raises a bus error.

When the cycle ends, a one-cycle done pulse presents the vector number, the vector table address and an outcome code to the core.

Top module: `irq_ack_arbiter`

## Requirements
- R1: While a cycle runs, `fc` is 3'b111 and `addr` is 24'hFFFF_F followed by `addr[3:1]` = acknowledged level and `addr[0]` = 1 (bits [23:4] all ones). When idle, `fc` and `addr` are zero.
- R2: A start with a nonzero level, accepted while idle with no done pulse showing, begins the cycle on the next edge and writes the level into `ipl_mask`. A start with level 0 is ignored.
- R3: Only sources whose level equals the acknowledged level and whose arbitration number is nonzero take part. The largest arbitration number wins, and equal numbers go to the lowest source index.
- R4: If the winner is ready without autovector, the cycle completes on that edge with `vec_num` = winner's vector and `outcome` = 2'd1.
- R5: If `avec` is high, or the ready winner asks for autovector, the cycle completes with `vec_num` = 24 + level and `outcome` = 2'd2. `avec` takes precedence over a supplied vector.
- R6: If no completion occurs, then on the L-th clock edge after the start edge the cycle ends with `bus_err` pulsed alongside `done`, `vec_num` = 24 and `outcome` = 2'd3. L is the clamped limit.
- R7: `vec_addr` = `vbr` + `vec_num`*4 modulo 2^32, using `vbr` as sampled at the completion edge.
- R8: A start while a cycle runs, or while `done` is high, is ignored and leaves `ipl_mask` unchanged.
- R9: The bus-monitor limit L is `mon_limit` clamped into 8..64.
- R10: After reset the block is idle, `done`, `bus_err`, `vec_num`, `vec_addr` and `outcome` are zero, and `ipl_mask` is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_start | input | 1 | Core requests an acknowledge |
| ack_level | input | 3 | Level to acknowledge |
| vbr | input | 32 | Vector base register value |
| mon_limit | input | 7 | Bus monitor limit in clocks (clamped 8..64) |
| avec | input | 1 | External autovector request |
| src_level | input | 24 | Request level per source, 3 bits each |
| src_arb | input | 32 | Arbitration number per source, 4 bits each |
| src_vec | input | 64 | Vector number per source, 8 bits each |
| src_autovec | input | 8 | Source asks for autovector |
| src_rdy | input | 8 | Source has placed its answer |
| fc | output | 3 | Function code |
| addr | output | 24 | Cycle address |
| busy | output | 1 | Cycle in progress |
| ipl_mask | output | 3 | Stored interrupt priority mask |
| done | output | 1 | Completion pulse |
| bus_err | output | 1 | Bus monitor error pulse |
| vec_num | output | 8 | Chosen vector number |
| vec_addr | output | 32 | Vector table address |
| outcome | output | 2 | 1 vectored, 2 autovector, 3 spurious |

## Verification
The bus outputs `fc` and `addr` follow one register, so they change right after the edge that accepts a start. The mask changes on that same edge. The vectored and autovector results appear right after the first edge on which the winner is ready or `avec` is high. A spurious result appears after the L-th edge following the start edge. The bench model steps on each rising edge from the same inputs, and every output is compared at the following falling edge. That way each result is checked exactly in the cycle it is due, and a late or early pulse shows up as a mismatch.

// File: rtl/iack_pkg.sv
package iack_pkg;

    localparam int LVL_W   = 3;
    localparam int VEC_W   = 8;
    localparam int ADR_W   = 24;
    localparam int VBR_W   = 32;
    localparam int MON_MIN = 8;
    localparam int MON_MAX = 64;

    localparam logic [2:0]       FC_CPU_SPACE = 3'b111;
    localparam logic [VEC_W-1:0] VEC_BASE     = 8'd24;

    typedef enum logic [1:0] {
        OUT_NONE     = 2'd0,
        OUT_VECTORED = 2'd1,
        OUT_AUTO     = 2'd2,
        OUT_SPUR     = 2'd3
    } iack_outcome_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } iack_state_e;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        iack_outcome_e    kind;
        logic             berr;
    } iack_result_t;

    function automatic logic [ADR_W-1:0] iack_address(input logic [LVL_W-1:0] lvl);
        return {{(ADR_W-LVL_W-1){1'b1}}, lvl, 1'b1};
    endfunction

    function automatic logic [VEC_W-1:0] autovec_number(input logic [LVL_W-1:0] lvl);
        return VEC_BASE + {{(VEC_W-LVL_W){1'b0}}, lvl};
    endfunction

    function automatic logic [VBR_W-1:0] table_address(input logic [VBR_W-1:0] base,
                                                       input logic [VEC_W-1:0] vec);
        return base + {{(VBR_W-VEC_W-2){1'b0}}, vec, 2'b00};
    endfunction

endpackage

// File: rtl/iack_arbiter.sv
module iack_arbiter
    import iack_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int ARB_W = 4,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   active,
    input  logic [LVL_W-1:0]       lvl,
    input  logic [NSRC*LVL_W-1:0]  src_level,
    input  logic [NSRC*ARB_W-1:0]  src_arb,
    output logic                   hit,
    output logic [IDX_W-1:0]       win_idx
);

    logic [LVL_W-1:0] lv_a [NSRC];
    logic [ARB_W-1:0] ab_a [NSRC];
    logic [NSRC-1:0]  elig;
    logic [ARB_W-1:0] best;

    for (genvar g = 0; g < NSRC; g++) begin : g_unpack
        assign lv_a[g] = src_level[g*LVL_W +: LVL_W];
        assign ab_a[g] = src_arb[g*ARB_W +: ARB_W];
        assign elig[g] = (lv_a[g] == lvl) && (ab_a[g] != '0);
    end

    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        best    = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!hit || ab_a[i] > best)) begin
                hit     = 1'b1;
                win_idx = i[IDX_W-1:0];
                best    = ab_a[i];
            end
        end
    end

    // R3: a chosen winner is always a matching, responding source
    p_winner_eligible_r3: assert property (@(posedge clk) disable iff (rst)
        (active && hit) |-> (lv_a[win_idx] == lvl && ab_a[win_idx] != '0));

    // R6: no winner only when nobody can respond
    p_nohit_means_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (active && !hit) |-> (elig == '0));

endmodule

// File: rtl/iack_busmon.sv
module iack_busmon
    import iack_pkg::*;
#(
    parameter int TMO_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    localparam logic [TMO_W-1:0] LIM_LO = TMO_W'(MON_MIN);
    localparam logic [TMO_W-1:0] LIM_HI = TMO_W'(MON_MAX);

    logic [TMO_W-1:0] cnt;
    logic [TMO_W-1:0] eff;

    always_comb begin
        if (limit < LIM_LO)      eff = LIM_LO;
        else if (limit > LIM_HI) eff = LIM_HI;
        else                     eff = limit;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == eff - 1'b1);

    // R9: the counter never runs past the largest window
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM_HI - 1'b1);

    // R9: expiry never comes before the smallest window
    p_expire_min_r9: assert property (@(posedge clk) disable iff (rst)
        expired |-> cnt >= LIM_LO - 1'b1);

endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
    import iack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LVL_W-1:0] level,
    input  logic [VBR_W-1:0] vbr,
    input  logic             avec,
    input  logic             hit,
    input  logic             win_rdy,
    input  logic             win_auto,
    input  logic [VEC_W-1:0] win_vec,
    input  logic             expired,
    output logic             busy,
    output logic [LVL_W-1:0] lvl_q,
    output logic [2:0]       fc,
    output logic [ADR_W-1:0] addr,
    output logic [LVL_W-1:0] ipl_mask,
    output logic             done,
    output logic             bus_err,
    output logic [VEC_W-1:0] vec_num,
    output logic [VBR_W-1:0] vec_addr,
    output logic [1:0]       outcome
);

    iack_state_e  state;
    iack_result_t res;
    logic         finish;
    logic         accept;

    assign busy   = (state == ST_RUN);
    assign accept = (state == ST_IDLE) && start && (level != '0) && !done;

    always_comb begin
        finish = 1'b1;
        res    = '{vec: '0, kind: OUT_NONE, berr: 1'b0};
        if (avec) begin
            res = '{vec: autovec_number(lvl_q), kind: OUT_AUTO, berr: 1'b0};
        end else if (hit && win_rdy) begin
            if (win_auto) res = '{vec: autovec_number(lvl_q), kind: OUT_AUTO, berr: 1'b0};
            else          res = '{vec: win_vec, kind: OUT_VECTORED, berr: 1'b0};
        end else if (expired) begin
            res = '{vec: VEC_BASE, kind: OUT_SPUR, berr: 1'b1};
        end else begin
            finish = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            lvl_q    <= '0;
            ipl_mask <= '1;
            done     <= 1'b0;
            bus_err  <= 1'b0;
            vec_num  <= '0;
            vec_addr <= '0;
            outcome  <= OUT_NONE;
        end else begin
            done    <= 1'b0;
            bus_err <= 1'b0;
            if (state == ST_RUN) begin
                if (finish) begin
                    state    <= ST_IDLE;
                    done     <= 1'b1;
                    bus_err  <= res.berr;
                    vec_num  <= res.vec;
                    vec_addr <= table_address(vbr, res.vec);
                    outcome  <= res.kind;
                end
            end else if (accept) begin
                state    <= ST_RUN;
                lvl_q    <= level;
                ipl_mask <= level;
            end
        end
    end

    always_comb begin
        fc   = busy ? FC_CPU_SPACE : 3'b000;
        addr = busy ? iack_address(lvl_q) : '0;
    end

    // R2: accepted level lands in the mask
    p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start && level != '0) |=> (busy && ipl_mask == $past(level)));

    // R2: level zero never starts a cycle
    p_level0_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && level == '0) |=> !busy);

    // R8: mask holds while a cycle runs
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ipl_mask));

    // R8: done pulse blocks a new start
    p_done_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R6: bus error comes only with a spurious completion
    p_berr_spur_r6: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (done && outcome == OUT_SPUR && vec_num == VEC_BASE));

    // R5: autovector numbers follow the mask level
    p_auto_num_r5: assert property (@(posedge clk) disable iff (rst)
        (done && outcome == OUT_AUTO) |-> vec_num == VEC_BASE + 8'(ipl_mask));

    // R7: table address from base sampled at completion
    p_vaddr_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> vec_addr == $past(vbr) + {22'b0, vec_num, 2'b00});

    // R1: address level field tracks the mask during a cycle
    p_addr_level_r1: assert property (@(posedge clk) disable iff (rst)
        busy |-> (addr[3:1] == ipl_mask && fc == FC_CPU_SPACE));

endmodule

// File: rtl/irq_ack_arbiter.sv
module irq_ack_arbiter
    import iack_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int ARB_W = 4,
    parameter int TMO_W = 7,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ack_start,
    input  logic [2:0]             ack_level,
    input  logic [31:0]            vbr,
    input  logic [TMO_W-1:0]       mon_limit,
    input  logic                   avec,
    input  logic [NSRC*3-1:0]      src_level,
    input  logic [NSRC*ARB_W-1:0]  src_arb,
    input  logic [NSRC*8-1:0]      src_vec,
    input  logic [NSRC-1:0]        src_autovec,
    input  logic [NSRC-1:0]        src_rdy,
    output logic [2:0]             fc,
    output logic [23:0]            addr,
    output logic                   busy,
    output logic [2:0]             ipl_mask,
    output logic                   done,
    output logic                   bus_err,
    output logic [7:0]             vec_num,
    output logic [31:0]            vec_addr,
    output logic [1:0]             outcome
);

    logic             hit;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] lvl_q;
    logic             expired;
    logic             win_rdy;
    logic             win_auto;
    logic [VEC_W-1:0] win_vec;

    iack_arbiter #(.NSRC(NSRC), .ARB_W(ARB_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .active    (busy),
        .lvl       (lvl_q),
        .src_level (src_level),
        .src_arb   (src_arb),
        .hit       (hit),
        .win_idx   (win_idx)
    );

    assign win_rdy  = src_rdy[win_idx];
    assign win_auto = src_autovec[win_idx];
    assign win_vec  = src_vec[win_idx*VEC_W +: VEC_W];

    iack_busmon #(.TMO_W(TMO_W)) u_mon (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .limit   (mon_limit),
        .expired (expired)
    );

    iack_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (ack_start),
        .level    (ack_level),
        .vbr      (vbr),
        .avec     (avec),
        .hit      (hit),
        .win_rdy  (win_rdy),
        .win_auto (win_auto),
        .win_vec  (win_vec),
        .expired  (expired),
        .busy     (busy),
        .lvl_q    (lvl_q),
        .fc       (fc),
        .addr     (addr),
        .ipl_mask (ipl_mask),
        .done     (done),
        .bus_err  (bus_err),
        .vec_num  (vec_num),
        .vec_addr (vec_addr),
        .outcome  (outcome)
    );

endmodule

// File: tb/irq_ack_arbiter_tb.sv
module irq_ack_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ack_start = 1'b0;
    logic [2:0]  ack_level = '0;
    logic [31:0] vbr = 32'h0000_1000;
    logic [6:0]  mon_limit = 7'd10;
    logic        avec = 1'b0;
    logic [23:0] src_level = '0;
    logic [31:0] src_arb = '0;
    logic [63:0] src_vec = '0;
    logic [7:0]  src_autovec = '0;
    logic [7:0]  src_rdy = '0;
    logic [2:0]  fc;
    logic [23:0] addr;
    logic        busy;
    logic [2:0]  ipl_mask;
    logic        done;
    logic        bus_err;
    logic [7:0]  vec_num;
    logic [31:0] vec_addr;
    logic [1:0]  outcome;

    always #2 clk = ~clk;

    irq_ack_arbiter u_dut (
        .clk(clk), .rst(rst), .ack_start(ack_start), .ack_level(ack_level),
        .vbr(vbr), .mon_limit(mon_limit), .avec(avec), .src_level(src_level),
        .src_arb(src_arb), .src_vec(src_vec), .src_autovec(src_autovec),
        .src_rdy(src_rdy), .fc(fc), .addr(addr), .busy(busy),
        .ipl_mask(ipl_mask), .done(done), .bus_err(bus_err),
        .vec_num(vec_num), .vec_addr(vec_addr), .outcome(outcome)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_tag  = "R10";

    // behavioural reference
    bit          m_run = 0, m_done = 0, m_berr = 0;
    int          m_lvl = 0, m_mask = 7, m_cnt = 0, m_out = 0, m_vec = 0;
    logic [31:0] m_vaddr = 0;

    task automatic check(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int limit_of();
        int l = mon_limit;
        if (l < 8) l = 8;
        if (l > 64) l = 64;
        return l;
    endfunction

    always @(posedge clk) begin
        bit dn, be;
        int best, nv, kind;
        if (rst) begin
            m_run = 0; m_done = 0; m_berr = 0; m_mask = 7;
            m_out = 0; m_vec = 0; m_vaddr = 0; m_cnt = 0;
        end else begin
            dn = 0; be = 0; kind = 0; nv = 0;
            if (m_run) begin
                best = -1;
                for (int i = 0; i < 8; i++) begin
                    if (src_level[i*3 +: 3] == m_lvl && src_arb[i*4 +: 4] != 0 &&
                        (best < 0 || src_arb[i*4 +: 4] > src_arb[best*4 +: 4]))
                        best = i;
                end
                if (avec) begin kind = 2; nv = 24 + m_lvl; end
                else if (best >= 0 && src_rdy[best]) begin
                    if (src_autovec[best]) begin kind = 2; nv = 24 + m_lvl; end
                    else begin kind = 1; nv = src_vec[best*8 +: 8]; end
                end else if (m_cnt == limit_of() - 1) begin kind = 3; nv = 24; be = 1; end
                else m_cnt++;
                if (kind != 0) begin
                    m_run = 0; dn = 1; m_out = kind; m_vec = nv;
                    m_vaddr = vbr + 32'(nv * 4);
                end
            end else if (ack_start && ack_level != 0 && !m_done) begin
                m_run = 1; m_lvl = ack_level; m_mask = ack_level; m_cnt = 0;
            end
            m_done = dn; m_berr = be;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R1", "fc", fc, m_run ? 7 : 0);
            check("R1", "addr", addr, m_run ? {20'hFFFFF, 3'(m_lvl), 1'b1} : 24'h0);
            check(cur_tag, "busy", busy, m_run);
            check(cur_tag, "ipl_mask", ipl_mask, m_mask);
            check(cur_tag, "done", done, m_done);
            check(cur_tag, "bus_err", bus_err, m_berr);
            check(cur_tag, "vec_num", vec_num, m_vec);
            check(cur_tag, "outcome", outcome, m_out);
            check("R7", "vec_addr", vec_addr, m_vaddr);
        end
    end

    task automatic clear_src();
        src_level = '0; src_arb = '0; src_vec = '0; src_autovec = '0; src_rdy = '0;
        avec = 1'b0;
    endtask

    task automatic set_src(int i, int lv, int ab, int vc, bit au);
        src_level[i*3 +: 3] = 3'(lv);
        src_arb[i*4 +: 4]   = 4'(ab);
        src_vec[i*8 +: 8]   = 8'(vc);
        src_autovec[i]      = au;
    endtask

    task automatic pulse_start(int lv);
        @(negedge clk);
        ack_start = 1'b1; ack_level = 3'(lv);
        @(negedge clk);
        ack_start = 1'b0;
    endtask

    task automatic settle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        for (int k = 0; k < 80 && !m_done; k++) @(negedge clk);
        settle(2);
        clear_src();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "busy", busy, 0);
        check("R10", "done", done, 0);
        check("R10", "ipl_mask", ipl_mask, 7);
        check("R10", "outcome", outcome, 0);
        check("R10", "vec_addr", vec_addr, 0);
        check("R10", "fc", fc, 0);
        rst = 1'b0;
        settle(2);

        cur_tag = "R4";        // single vectored source, ready at once
        set_src(2, 5, 3, 8'h40, 0); src_rdy[2] = 1;
        pulse_start(5); finish_run();

        cur_tag = "R3";        // contention, higher arb wins, other level ignored
        set_src(0, 4, 2, 8'h50, 0); set_src(5, 4, 9, 8'h55, 0);
        set_src(6, 3, 15, 8'h66, 0); src_rdy = 8'hFF;
        pulse_start(4); finish_run();

        cur_tag = "R3";        // tie goes to lowest index, delayed ready
        set_src(3, 6, 7, 8'h73, 0); set_src(6, 6, 7, 8'h76, 0);
        pulse_start(6); settle(3); src_rdy = 8'hFF; finish_run();

        cur_tag = "R5";        // winner asks for autovector
        set_src(1, 2, 5, 8'h99, 1); src_rdy[1] = 1;
        pulse_start(2); finish_run();

        cur_tag = "R5";        // external autovector overrides supplied vector
        set_src(4, 7, 5, 8'h88, 0); src_rdy[4] = 1; avec = 1;
        pulse_start(7); finish_run();

        cur_tag = "R6";        // only zero arb numbers: spurious after limit
        set_src(0, 3, 0, 8'h11, 0); src_rdy = 8'hFF; mon_limit = 7'd10;
        pulse_start(3); finish_run();

        cur_tag = "R9";        // small limit clamped to 8
        mon_limit = 7'd3;
        pulse_start(1); finish_run();

        cur_tag = "R9";        // large limit clamped to 64
        mon_limit = 7'd100;
        pulse_start(2); finish_run();
        mon_limit = 7'd10;

        cur_tag = "R2";        // level zero ignored
        set_src(0, 0, 4, 8'h20, 0); src_rdy = 8'hFF;
        pulse_start(0); settle(3); clear_src();

        cur_tag = "R8";        // start while busy ignored
        set_src(2, 3, 4, 8'h31, 0);
        pulse_start(3); pulse_start(6); settle(2);
        src_rdy[2] = 1; finish_run();

        cur_tag = "R8";        // start held across the done pulse
        set_src(2, 5, 4, 8'h52, 0); src_rdy[2] = 1;
        @(negedge clk); ack_start = 1; ack_level = 5;
        settle(4); ack_start = 0; finish_run();

        cur_tag = "R7";        // base wraps past 2^32
        vbr = 32'hFFFF_FFF0;
        set_src(7, 1, 1, 8'hC8, 0); src_rdy[7] = 1;
        pulse_start(1); finish_run();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule